// File: doc/BRIEF.md
# Latency-Limited Burst Master

This block moves words from an internal 128-byte transmit buffer onto a shared 32-bit bus as a bus master. Once the buffer holds enough words, or a drain is demanded, it raises a request. When the arbiter grants the bus, the block drives one address cycle and then streams data cycles until one of two things happens. Either the buffer runs dry, or the bus tenure reaches the limit set by a programmable latency timer.

The timer counts every cycle the block owns the bus. That includes the address cycle and cycles where the target holds off with target-ready low. When the timer runs out while data is still queued, the block gives the bus back. It spends one idle turnaround cycle, requests again, and restarts at the address that follows the last word accepted. When the buffer empties first, it releases the bus at once.

Two counters report the total bytes delivered and how many tenures the timer cut short.

Top module: `burst_master`

## Requirements
- R1: After reset, req, frame and irdy are low, ad is zero, wr_ready is high and both status counters are zero.
- R2: The buffer holds 32 words (128 bytes). wr_ready is low exactly when it is full. A write offered while wr_ready is low is dropped and never appears on the bus.
- R3: When idle and thr_words is nonzero, req rises once the buffer level reaches thr_words. Below that level it stays low. A thr_words of zero disables this trigger.
- R4: A one-cycle flush pulse makes the block request with any nonzero level. The block then keeps transferring until the buffer is empty.
- R5: While req is high and gnt is low, frame stays low. An address cycle follows only a cycle with req and gnt both high. In that cycle frame is 1, irdy is 0 and ad carries the current address.
- R6: Every cycle after the address cycle within a tenure has frame and irdy high, with ad showing the oldest buffered word. A word counts as delivered in a cycle with trdy high. Words are delivered in write order, each exactly once.
- R7: A tenure ends right after its last buffered word is delivered, even if the timer has not run out. This early end does not count as a preemption.
- R8: A tenure lasts at most L cycles, counting the address cycle and wait cycles with trdy low. L is the active latency setting. If words are still buffered when the limit is reached, the tenure is exactly L cycles long, preempt_cnt increments, and req is raised again.
- R9: Each address cycle carries the start address plus 4 times the number of words delivered since that address was loaded. After a preemption, the next tenure therefore continues where the last one stopped.
- R10: After frame falls, frame, irdy and req all stay low for one turnaround cycle.
- R11: The latency setting resets to 32. lat_we loads lat_val, and values below 2 are raised to 2. A new setting applies from the next address cycle.
- R12: bytes_total grows by 4 for every delivered word.
- R13: addr_load sets the start address only while the block is idle (req and frame low). At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe into the transmit buffer |
| wr_data | input | 32 | Word to buffer |
| wr_ready | output | 1 | Buffer has room |
| flush | input | 1 | Pulse: drain everything buffered |
| thr_words | input | 6 | Level that triggers a request (0 = off) |
| addr_load | input | 1 | Load a new start address (idle only) |
| addr_in | input | 32 | Start address to load |
| lat_we | input | 1 | Write the latency setting |
| lat_val | input | 8 | New latency setting in cycles |
| gnt | input | 1 | Bus grant |
| trdy | input | 1 | Target ready |
| req | output | 1 | Bus request |
| frame | output | 1 | Bus tenure active |
| irdy | output | 1 | Initiator ready (data cycle) |
| ad | output | 32 | Address in the address cycle, data in data cycles |
| bytes_total | output | 32 | Bytes delivered since reset |
| preempt_cnt | output | 16 | Tenures ended by the latency timer |

## Verification
The assertions check the following on every cycle:
- irdy is never high outside frame.
- Every address cycle follows a granted request.
- A turnaround gap follows each tenure.
- req never rises with an empty buffer.
- The buffer level never exceeds its depth.
- The tenure counter stays below the active limit, and that limit is never below 2.

The bench scenarios show the behaviour that depends on sequences and arithmetic:
- exact tenure lengths under early end versus preemption, including wait cycles;
- the resumed address after a cut-off;
- the dropped write on a full buffer;
- the threshold, flush and idle-only address load rules;
- the clamped latency setting and the byte total.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int WORD_W         = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } bus_state_t;

    typedef struct packed {
        logic req;
        logic frame;
        logic irdy;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_of(input bus_state_t s);
        bus_ctl_t c;
        c.req   = (s == ST_REQ);
        c.frame = (s == ST_ADDR) || (s == ST_DATA);
        c.irdy  = (s == ST_DATA);
        return c;
    endfunction
endpackage

// File: rtl/bm_fifo.sv
module bm_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

    // R6
    pop_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/bm_tenure.sv
module bm_tenure #(
    parameter int LAT_W     = 8,
    parameter int LAT_RESET = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [LAT_W-1:0] cfg_val,
    input  logic             start,
    input  logic             run,
    output logic             last
);
    localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);
    localparam logic [LAT_W:0]   ONE     = (LAT_W+1)'(1);

    logic [LAT_W-1:0] lat_q, lat_act, tcnt;
    logic [LAT_W:0]   used_after;

    always_ff @(posedge clk) begin
        if (rst)         lat_q <= LAT_W'(LAT_RESET);
        else if (cfg_we) lat_q <= (cfg_val < LAT_MIN) ? LAT_MIN : cfg_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_act <= LAT_W'(LAT_RESET);
            tcnt    <= '0;
        end else if (start) begin
            lat_act <= lat_q;
            tcnt    <= LAT_W'(1);
        end else if (run) begin
            tcnt    <= tcnt + 1'b1;
        end
    end

    assign used_after = {1'b0, tcnt} + ONE;
    assign last       = run && (used_after >= {1'b0, lat_act});

    // R8
    tenure_cap_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (tcnt < lat_act));

    // R11
    lat_floor_chk: assert property (@(posedge clk) disable iff (rst)
        lat_act >= LAT_MIN);
endmodule

// File: rtl/bm_stats.sv
module bm_stats #(
    parameter int BYTE_CNT_W = 32,
    parameter int PRE_W      = 16,
    parameter int STEP       = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  phase_done,
    input  logic                  preempt,
    output logic [BYTE_CNT_W-1:0] bytes_total,
    output logic [PRE_W-1:0]      preempt_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_total <= '0;
            preempt_cnt <= '0;
        end else begin
            if (phase_done) bytes_total <= bytes_total + BYTE_CNT_W'(STEP);
            if (preempt)    preempt_cnt <= preempt_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/burst_master.sv
module burst_master
    import bm_pkg::*;
#(
    parameter int FIFO_BYTES = 128,
    parameter int LAT_W      = 8,
    parameter int LAT_RESET  = 32,
    parameter int BYTE_CNT_W = 32,
    parameter int PRE_W      = 16,
    localparam int DEPTH     = FIFO_BYTES / BYTES_PER_WORD,
    localparam int CW        = $clog2(DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic [WORD_W-1:0]     wr_data,
    output logic                  wr_ready,
    input  logic                  flush,
    input  logic [CW-1:0]         thr_words,
    input  logic                  addr_load,
    input  logic [WORD_W-1:0]     addr_in,
    input  logic                  lat_we,
    input  logic [LAT_W-1:0]      lat_val,
    input  logic                  gnt,
    input  logic                  trdy,
    output logic                  req,
    output logic                  frame,
    output logic                  irdy,
    output logic [WORD_W-1:0]     ad,
    output logic [BYTE_CNT_W-1:0] bytes_total,
    output logic [PRE_W-1:0]      preempt_cnt
);
    bus_state_t        st_q, st_d;
    bus_ctl_t          ctl;
    logic [CW-1:0]     lvl;
    logic              full, empty;
    logic [WORD_W-1:0] head;
    logic [WORD_W-1:0] addr_q;
    logic              flush_q, resume_q;
    logic              push_ok, in_addr, in_data, phase_done;
    logic              last_word, timer_last, preempt, want_bus;

    assign push_ok    = wr_valid && !full;
    assign wr_ready   = !full;
    assign in_addr    = (st_q == ST_ADDR);
    assign in_data    = (st_q == ST_DATA);
    assign phase_done = in_data && trdy;
    assign last_word  = phase_done && (lvl == CW'(1)) && !push_ok;
    assign want_bus   = !empty &&
                        (flush_q || ((thr_words != '0) && (lvl >= thr_words)));

    bm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push_ok),
        .din   (wr_data),
        .pop   (phase_done),
        .dout  (head),
        .count (lvl),
        .full  (full),
        .empty (empty)
    );

    bm_tenure #(.LAT_W(LAT_W), .LAT_RESET(LAT_RESET)) u_tenure (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (lat_we),
        .cfg_val (lat_val),
        .start   (in_addr),
        .run     (in_data),
        .last    (timer_last)
    );

    bm_stats #(.BYTE_CNT_W(BYTE_CNT_W), .PRE_W(PRE_W), .STEP(BYTES_PER_WORD)) u_stats (
        .clk         (clk),
        .rst         (rst),
        .phase_done  (phase_done),
        .preempt     (preempt),
        .bytes_total (bytes_total),
        .preempt_cnt (preempt_cnt)
    );

    always_comb begin
        st_d    = st_q;
        preempt = 1'b0;
        unique case (st_q)
            ST_IDLE: if (want_bus) st_d = ST_REQ;
            ST_REQ:  if (gnt)      st_d = ST_ADDR;
            ST_ADDR:               st_d = ST_DATA;
            ST_DATA: begin
                if (last_word) begin
                    st_d = ST_TURN;
                end else if (timer_last) begin
                    st_d    = ST_TURN;
                    preempt = 1'b1;
                end
            end
            ST_TURN: st_d = resume_q ? ST_REQ : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            resume_q <= 1'b0;
            flush_q  <= 1'b0;
            addr_q   <= '0;
        end else begin
            st_q    <= st_d;
            flush_q <= flush || (flush_q && !empty);
            if (in_data) resume_q <= preempt;
            if ((st_q == ST_IDLE) && addr_load)
                addr_q <= addr_in;
            else if (phase_done)
                addr_q <= addr_q + WORD_W'(BYTES_PER_WORD);
        end
    end

    assign ctl   = ctl_of(st_q);
    assign req   = ctl.req;
    assign frame = ctl.frame;
    assign irdy  = ctl.irdy;
    assign ad    = in_addr ? addr_q : (in_data ? head : '0);

    // R6
    irdy_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        irdy |-> frame);

    // R5
    addr_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (frame && !irdy) |-> $past(req && gnt));

    // R10
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame) |=> (!frame && !irdy));

    // R10
    turn_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame) |-> !req);

    // R3
    req_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> !empty);
endmodule

// File: tb/test_burst_master.sv
module test_burst_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        flush = 1'b0;
    logic [5:0]  thr_words = '0;
    logic        addr_load = 1'b0;
    logic [31:0] addr_in = '0;
    logic        lat_we = 1'b0;
    logic [7:0]  lat_val = '0;
    logic        gnt = 1'b0;
    logic        trdy = 1'b1;
    logic        req, frame, irdy;
    logic [31:0] ad;
    logic [31:0] bytes_total;
    logic [15:0] preempt_cnt;

    burst_master i_burst_master (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .flush(flush), .thr_words(thr_words),
        .addr_load(addr_load), .addr_in(addr_in), .lat_we(lat_we),
        .lat_val(lat_val), .gnt(gnt), .trdy(trdy), .req(req), .frame(frame),
        .irdy(irdy), .ad(ad), .bytes_total(bytes_total), .preempt_cnt(preempt_cnt)
    );

    always #5 clk = ~clk;

    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;
    logic [31:0] exp_q[$];
    logic [31:0] next_val = 32'h1000_0001;
    logic [31:0] exp_addr = '0;
    int          lat_model = 32;
    int          delivered = 0;
    int          refused = 0;
    int          last_len = 0;
    int          ten_len = 0;
    bit          in_ten = 0;
    bit          req_seen = 0;
    bit          gnt_block = 0;
    bit          trdy_alt = 0;
    logic [15:0] pre_at_start = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // bus-side responders: grant follows request, target ready pattern
    always @(negedge clk) begin
        gnt  <= gnt_block ? 1'b0 : req;
        trdy <= trdy_alt ? ~trdy : 1'b1;
    end

    // monitor: pops the scoreboard as words are delivered
    always begin
        @(negedge clk);
        #3;
        if (!rst) begin
            if (req) req_seen = 1;
            if (frame && !irdy) begin
                chk(ad == exp_addr, "R5/R9 address cycle", ad, exp_addr);
                in_ten = 1;
                ten_len = 1;
                pre_at_start = preempt_cnt;
            end else if (frame && irdy) begin
                ten_len++;
                if (trdy) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 unexpected word", ad, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(ad == e, "R6 data order", ad, e);
                    end
                    exp_addr += 4;
                    delivered++;
                end
            end else if (in_ten) begin
                in_ten = 0;
                last_len = ten_len;
                chk(!req && !irdy, "R10 turnaround", {req, irdy}, 0);
                chk(ten_len <= lat_model, "R8 tenure cap", ten_len, lat_model);
                if (preempt_cnt != pre_at_start)
                    chk(ten_len == lat_model, "R8 preempted tenure length", ten_len, lat_model);
            end
        end
    end

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = next_val;
            if (wr_ready) begin
                exp_q.push_back(next_val);
                next_val++;
            end else begin
                refused++;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic set_lat(input int v);
        @(negedge clk); lat_we = 1'b1; lat_val = 8'(v);
        @(negedge clk); lat_we = 1'b0;
        lat_model = (v < 2) ? 2 : v;
    endtask

    task automatic set_addr(input logic [31:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a; exp_addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !req && !frame && !in_ten) break;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 drain complete", exp_q.size(), 0);
    endtask

    initial begin
        logic [15:0] p0;
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        chk(!req && !frame && !irdy, "R1 bus idle in reset", {req, frame, irdy}, 0);
        chk(ad == 0 && wr_ready, "R1 ad zero / ready", ad, 0);
        chk(bytes_total == 0 && preempt_cnt == 0, "R1 counters", bytes_total, 0);
        @(negedge clk); rst = 1'b0;
        set_addr(32'h0000_4000);

        // R2 + R11 default: fill buffer with the trigger off, then flush
        thr_words = 6'd0;
        push_words(33);
        #3;
        chk(refused == 1, "R2 write dropped when full", refused, 1);
        chk(!wr_ready, "R2 wr_ready low when full", wr_ready, 0);
        chk(!req && !frame, "R3 zero threshold holds off", req, 0);
        p0 = preempt_cnt;
        pulse_flush();
        wait_drained();
        chk(preempt_cnt - p0 == 1, "R11 default 32 forces one preemption", preempt_cnt - p0, 1);
        chk(last_len == 2, "R7 final short tenure", last_len, 2);

        // R3 threshold trigger
        thr_words = 6'd4;
        req_seen = 0;
        push_words(3);
        repeat (6) @(negedge clk);
        chk(!req_seen, "R3 below threshold no request", req_seen, 0);
        push_words(1);
        repeat (4) @(negedge clk);
        chk(req_seen, "R3 request at threshold", req_seen, 1);
        wait_drained();
        chk(last_len == 5, "R7 early end length", last_len, 5);

        // R4 flush below threshold, R7 early end
        thr_words = 6'd0;
        req_seen = 0;
        push_words(3);
        repeat (6) @(negedge clk);
        chk(!req_seen, "R4 no request before flush", req_seen, 0);
        p0 = preempt_cnt;
        pulse_flush();
        wait_drained();
        chk(last_len == 4, "R7 tenure ends when empty", last_len, 4);
        chk(preempt_cnt == p0, "R7 early end not a preemption", preempt_cnt, p0);

        // R8 / R9 preemption at lat 8, resumed addresses checked by monitor
        set_lat(8);
        set_addr(32'h0010_0000);
        push_words(20);
        p0 = preempt_cnt;
        pulse_flush();
        wait_drained();
        chk(preempt_cnt - p0 == 2, "R8 two preemptions for 20 words", preempt_cnt - p0, 2);
        chk(last_len == 7, "R8 remainder tenure", last_len, 7);
        chk(exp_addr == 32'h0010_0050, "R9 address after resumes", exp_addr, 32'h0010_0050);

        // R8 wait cycles count against the timer
        set_lat(6);
        trdy_alt = 1;
        push_words(6);
        p0 = preempt_cnt;
        pulse_flush();
        wait_drained();
        chk(preempt_cnt != p0, "R8 wait cycles cause preemption", preempt_cnt - p0, 1);
        trdy_alt = 0;

        // R5 no address cycle without grant
        gnt_block = 1;
        push_words(2);
        pulse_flush();
        repeat (10) @(negedge clk);
        #3;
        chk(req && !frame, "R5 waits for grant", {req, frame}, 2);
        gnt_block = 0;
        wait_drained();

        // R11 clamp to 2 and R13 load ignored during activity
        set_lat(1);
        push_words(3);
        p0 = preempt_cnt;
        pulse_flush();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (frame) break;
        end
        addr_load = 1'b1; addr_in = 32'hDEAD_0000;
        @(negedge clk); addr_load = 1'b0;
        wait_drained();
        chk(preempt_cnt - p0 == 2, "R11 clamped setting preempts", preempt_cnt - p0, 2);
        chk(last_len == 2, "R11 tenure of two cycles", last_len, 2);

        // R12 byte total
        chk(bytes_total == 32'(delivered * 4), "R12 bytes total", bytes_total, delivered * 4);
        finish_run();
    end
endmodule